// File: doc/BRIEF.md
# Output Fault Protection Supervisor

This block decides when the five power outputs of a driver stage must be forced off. Four outputs are half-bridges and one is a high-side switch. Three kinds of fault indication reach it as synchronous inputs:

- a current-limit flag for each output;
- a supply overvoltage flag;
- an unsigned junction temperature code.

From these it builds a per-output force-off mask and four diagnostic bits.

**Over-current.** An over-current is not tripped at once. An output is switched off only after its current-limit flag has stayed high for a whole window of clock cycles. Each output then stays latched off until the controller issues a write command. The latched faults are reported as two flags: one shared by the half-bridge group, and one for the high-side output.

**Overvoltage.** Overvoltage forces every output off while it lasts. When it ends, the mask returns to what it was before, and no new command is needed.

**Temperature.** Temperature drives a hysteretic shutdown. A separate warning bit is raised at a fixed offset below the shutdown level.

**Structure.** Each output has its own small state machine:
- `OC_IDLE`, left for `OC_COUNT` when the limit flag is high;
- `OC_COUNT`, returning to `OC_IDLE` when the flag drops, or moving to `OC_TRIP` at the end of the window;
- `OC_TRIP`, left only by a write strobe, which takes any state back to `OC_IDLE`.

The thermal machine has two states: `TH_RUN` goes to `TH_HOT` at the shutdown level, and `TH_HOT` returns to `TH_RUN` below the release level. The supply machine also has two: `SV_NORMAL` goes to `SV_OVER` while overvoltage is flagged, and `SV_OVER` returns to `SV_NORMAL` when it clears.

**Parameters.** The window length `OC_WIN_CYC` must be at least 2. All outputs are registered, so an output reflects the inputs sampled at the previous clock edge.

Top module: `ofp_supervisor`

## Requirements
- R1: While reset is low, and on the first cycle after it, `force_off_o`, `ovc_hb_o`, `ovc_hs_o`, `ovv_o` and `twarn_o` are all zero.
- R2: An output is forced off once its `ilim_i` bit has been high at `OC_WIN_CYC` consecutive clock edges, and not before. A single low sample restarts that output's window from zero.
- R3: Once tripped, an output stays forced off whatever its `ilim_i` does. A `wr_stb_i` pulse clears every trip and restarts every window.
- R4: A trip on any half-bridge output (bits 0 to `NUM_HB-1`) sets `ovc_hb_o`. A trip on the high-side output (bit `NUM_HB`) sets `ovc_hs_o`.
- R5: One cycle after `ovv_i` is sampled high, all `force_off_o` bits are 1 and `ovv_o` is 1.
- R6: After `ovv_i` drops, `force_off_o` returns to the latched trip mask without any write strobe.
- R7: `temp_i >= T_SHUT` forces all outputs off. They stay off until `temp_i < T_SHUT - T_HYST`.
- R8: `twarn_o` is 1 exactly when the `temp_i` sampled at the previous edge is at least `T_SHUT - T_WARN`.
- R9: Every output changes only one cycle after the input sample that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ilim_i | input | NUM_HB+1 | Current-limit-active flag per output; the high-side output is the top bit |
| ovv_i | input | 1 | Supply above the overvoltage threshold |
| temp_i | input | TEMP_W | Junction temperature code, unsigned |
| wr_stb_i | input | 1 | Write command strobe; re-arms latched over-current faults |
| force_off_o | output | NUM_HB+1 | Per-output force-off (high impedance) mask |
| ovc_hb_o | output | 1 | Over-current latched on some half-bridge output |
| ovc_hs_o | output | 1 | Over-current latched on the high-side output |
| ovv_o | output | 1 | Overvoltage diagnostic |
| twarn_o | output | 1 | Temperature warning diagnostic |

## Verification
The bench builds the block with a 16-cycle window, four half-bridges, 8-bit temperature, a shutdown level of 200, a hysteresis of 15 and a warning offset of 30. The short window makes trips, window restarts after a single low sample, and re-arming reachable many times within a few thousand cycles. The chosen thresholds put the warning edge (169/170) and the hysteresis edges (184/185/200) within a small temperature range. A random phase then mixes long current-limit runs with overvoltage bursts and a wandering temperature. This drives the over-current, overvoltage and thermal conditions at the same time, which exercises the restore-after-overvoltage behaviour on top of existing trips.

// File: rtl/ofp_pkg.sv
package ofp_pkg;

    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,
        OC_COUNT = 2'd1,
        OC_TRIP  = 2'd2
    } oc_state_e;

    typedef enum logic {
        TH_RUN = 1'b0,
        TH_HOT = 1'b1
    } th_state_e;

    typedef enum logic {
        SV_NORMAL = 1'b0,
        SV_OVER   = 1'b1
    } sv_state_e;

endpackage

// File: rtl/ofp_oc_timer.sv
module ofp_oc_timer
    import ofp_pkg::*;
#(
    parameter int WIN_CYC = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ilim_i,
    input  logic rearm_i,
    output logic tripped_o
);

    localparam int            CW       = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    oc_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State and counter registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= OC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic. A rearm strobe wins over everything else.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rearm_i) begin
            state_d = OC_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                OC_IDLE: begin
                    if (ilim_i) begin
                        state_d = OC_COUNT;
                        cnt_d   = CNT_ONE;
                    end
                end
                OC_COUNT: begin
                    if (!ilim_i) begin
                        state_d = OC_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = OC_TRIP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                OC_TRIP: begin
                    state_d = OC_TRIP;
                end
                default: begin
                    state_d = OC_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign tripped_o = (state_q == OC_TRIP);

    AST_TRIP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == OC_TRIP && !rearm_i) |=> (state_q == OC_TRIP)); // R3
    AST_REARM_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rearm_i |=> (state_q == OC_IDLE && cnt_q == '0)); // R3
    AST_TRIP_NEEDS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tripped_o) |-> $past(ilim_i)); // R2
    AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < CW'(WIN_CYC)); // R2

endmodule

// File: rtl/ofp_thermal_guard.sv
module ofp_thermal_guard
    import ofp_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int T_SHUT = 200,
    parameter int T_HYST = 15,
    parameter int T_WARN = 30
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              hot_o,
    output logic              warn_o
);

    localparam logic [TEMP_W-1:0] LVL_SHUT = TEMP_W'(T_SHUT);
    localparam logic [TEMP_W-1:0] LVL_REL  = TEMP_W'(T_SHUT - T_HYST);
    localparam logic [TEMP_W-1:0] LVL_WARN = TEMP_W'(T_SHUT - T_WARN);

    th_state_e state_q, state_d;
    logic      warn_q;

    // State register and registered warning bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= TH_RUN;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            warn_q  <= (temp_i >= LVL_WARN);
        end
    end

    // Next-state logic with hysteresis between shutdown and release levels.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_RUN: if (temp_i >= LVL_SHUT) state_d = TH_HOT;
            TH_HOT: if (temp_i < LVL_REL)   state_d = TH_RUN;
            default: state_d = TH_RUN;
        endcase
    end

    assign hot_o  = (state_q == TH_HOT);
    assign warn_o = warn_q;

    AST_HOT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hot_o) |-> ($past(temp_i) >= LVL_SHUT)); // R7
    AST_HOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hot_o && temp_i >= LVL_REL) |=> hot_o); // R7
    AST_HOT_WARNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (temp_i >= LVL_SHUT) |=> warn_o); // R8

endmodule

// File: rtl/ofp_supply_guard.sv
module ofp_supply_guard
    import ofp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ovv_i,
    output logic over_o
);

    sv_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= SV_NORMAL;
        else         state_q <= state_d;
    end

    // Next-state logic: the machine tracks the overvoltage flag.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_NORMAL: if (ovv_i)  state_d = SV_OVER;
            SV_OVER:   if (!ovv_i) state_d = SV_NORMAL;
            default:   state_d = SV_NORMAL;
        endcase
    end

    assign over_o = (state_q == SV_OVER);

    AST_OVV_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovv_i |=> over_o); // R5
    AST_OVV_LEAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ovv_i |=> !over_o); // R6

endmodule

// File: rtl/ofp_supervisor.sv
module ofp_supervisor
    import ofp_pkg::*;
#(
    parameter int NUM_HB     = 4,
    parameter int OC_WIN_CYC = 5000,
    parameter int TEMP_W     = 8,
    parameter int T_SHUT     = 200,
    parameter int T_HYST     = 15,
    parameter int T_WARN     = 30
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_HB:0]   ilim_i,
    input  logic              ovv_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              wr_stb_i,
    output logic [NUM_HB:0]   force_off_o,
    output logic              ovc_hb_o,
    output logic              ovc_hs_o,
    output logic              ovv_o,
    output logic              twarn_o
);

    localparam int NUM_OUT = NUM_HB + 1;

    logic [NUM_OUT-1:0] trip_mask;
    logic               th_hot;
    logic               sv_over;

    // One over-current window timer per output.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_oc
        ofp_oc_timer #(
            .WIN_CYC (OC_WIN_CYC)
        ) i_oc_timer (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ilim_i    (ilim_i[g]),
            .rearm_i   (wr_stb_i),
            .tripped_o (trip_mask[g])
        );
    end

    ofp_thermal_guard #(
        .TEMP_W (TEMP_W),
        .T_SHUT (T_SHUT),
        .T_HYST (T_HYST),
        .T_WARN (T_WARN)
    ) i_thermal (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .temp_i (temp_i),
        .hot_o  (th_hot),
        .warn_o (twarn_o)
    );

    ofp_supply_guard i_supply (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ovv_i  (ovv_i),
        .over_o (sv_over)
    );

    // The latched trip mask is kept during overvoltage and thermal
    // shutdown, so it is what remains once those conditions clear.
    assign force_off_o = trip_mask | {NUM_OUT{sv_over | th_hot}};
    assign ovc_hb_o    = |trip_mask[NUM_HB-1:0];
    assign ovc_hs_o    = trip_mask[NUM_HB];
    assign ovv_o       = sv_over;

    AST_OVV_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovv_o |-> (&force_off_o)); // R5
    AST_HS_FLAG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovc_hs_o |-> force_off_o[NUM_HB]); // R4
    AST_HB_FLAG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovc_hb_o |-> (|force_off_o[NUM_HB-1:0])); // R4
    AST_WR_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_i |=> (!ovc_hb_o && !ovc_hs_o)); // R3

endmodule

// File: tb/test_ofp_supervisor.sv
module test_ofp_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_HB     = 4;
    localparam int NUM_OUT    = NUM_HB + 1;
    localparam int OC_WIN     = 16;
    localparam int TEMP_W     = 8;
    localparam int T_SHUT     = 200;
    localparam int T_HYST     = 15;
    localparam int T_WARN     = 30;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_HB:0]   ilim = '0;
    logic              ovv = 1'b0;
    logic [TEMP_W-1:0] temp = '0;
    logic              wr = 1'b0;
    logic [NUM_HB:0]   force_off;
    logic              ovc_hb, ovc_hs, ovv_d, twarn;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model state
    int cnt_m [NUM_OUT];
    bit trip_m[NUM_OUT];
    bit hot_m  = 1'b0;
    bit ovq_m  = 1'b0;
    bit warn_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofp_supervisor #(
        .NUM_HB     (NUM_HB),
        .OC_WIN_CYC (OC_WIN),
        .TEMP_W     (TEMP_W),
        .T_SHUT     (T_SHUT),
        .T_HYST     (T_HYST),
        .T_WARN     (T_WARN)
    ) i_ofp_supervisor (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ilim_i      (ilim),
        .ovv_i       (ovv),
        .temp_i      (temp),
        .wr_stb_i    (wr),
        .force_off_o (force_off),
        .ovc_hb_o    (ovc_hb),
        .ovc_hs_o    (ovc_hs),
        .ovv_o       (ovv_d),
        .twarn_o     (twarn)
    );

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                cnt_m[i]  = 0;
                trip_m[i] = 1'b0;
            end
            hot_m = 1'b0; ovq_m = 1'b0; warn_m = 1'b0;
        end else begin
            for (int i = 0; i < NUM_OUT; i++) begin
                if (wr) begin
                    trip_m[i] = 1'b0; cnt_m[i] = 0;
                end else if (!trip_m[i]) begin
                    if (ilim[i]) begin
                        cnt_m[i] = cnt_m[i] + 1;
                        if (cnt_m[i] >= OC_WIN) begin
                            trip_m[i] = 1'b1; cnt_m[i] = 0;
                        end
                    end else begin
                        cnt_m[i] = 0;
                    end
                end
            end
            if (!hot_m && int'(temp) >= T_SHUT) hot_m = 1'b1;
            else if (hot_m && int'(temp) < T_SHUT - T_HYST) hot_m = 1'b0;
            warn_m = (int'(temp) >= T_SHUT - T_WARN);
            ovq_m  = ovv;
        end
    end

    function automatic logic [NUM_HB:0] exp_force();
        logic [NUM_HB:0] m;
        for (int i = 0; i < NUM_OUT; i++) m[i] = trip_m[i] | ovq_m | hot_m;
        return m;
    endfunction

    function automatic bit exp_hb();
        bit b = 1'b0;
        for (int i = 0; i < NUM_HB; i++) b |= trip_m[i];
        return b;
    endfunction

    // Per-cycle comparison against the model (R9: one-cycle latency)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (force_off !== exp_force()) begin
                errors++;
                $display("FAIL R9 R2 R5 R7 force_off: actual=%b expected=%b", force_off, exp_force());
            end
            checks++;
            if (ovc_hb !== exp_hb() || ovc_hs !== trip_m[NUM_HB]) begin
                errors++;
                $display("FAIL R9 R4 flags: actual=%b%b expected=%b%b", ovc_hb, ovc_hs, exp_hb(), trip_m[NUM_HB]);
            end
            checks++;
            if (ovv_d !== ovq_m || twarn !== warn_m) begin
                errors++;
                $display("FAIL R9 R5 R8 diag: actual=%b%b expected=%b%b", ovv_d, twarn, ovq_m, warn_m);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        step(3);
        chk("R1 reset force_off", 32'(force_off), 32'h0);
        chk("R1 reset diag", {28'h0, ovc_hb, ovc_hs, ovv_d, twarn}, 32'h0);
        rst_n = 1'b1;
        step(1);
        chk("R1 first cycle after reset", {27'h0, force_off}, 32'h0);

        // R2: window boundary and restart
        ilim[0] = 1'b1; step(OC_WIN - 1);
        chk("R2 no trip one short", 32'(force_off), 32'h0);
        ilim[0] = 1'b0; step(1);
        ilim[0] = 1'b1; step(OC_WIN - 1);
        chk("R2 window restarted", 32'(force_off), 32'h0);
        step(1);
        chk("R2 trip at full window", 32'(force_off), 32'h01);
        chk("R4 half-bridge flag", {30'h0, ovc_hb, ovc_hs}, 32'h2);

        // R3: latched
        ilim[0] = 1'b0; step(5);
        chk("R3 stays latched", 32'(force_off), 32'h01);

        // R5 / R6: overvoltage and restore
        ovv = 1'b1; step(1);
        chk("R5 all off", 32'(force_off), 32'h1F);
        chk("R5 ovv flag", 32'(ovv_d), 32'h1);
        ovv = 1'b0; step(1);
        chk("R6 prior mask restored", 32'(force_off), 32'h01);

        // R3: write re-arms
        wr = 1'b1; step(1); wr = 1'b0;
        chk("R3 write clears", 32'(force_off), 32'h0);
        chk("R3 flags cleared", {30'h0, ovc_hb, ovc_hs}, 32'h0);

        // R4: high-side flag
        ilim[NUM_HB] = 1'b1; step(OC_WIN);
        chk("R4 high-side trip", 32'(force_off), 32'h10);
        chk("R4 high-side flag", {30'h0, ovc_hb, ovc_hs}, 32'h1);
        ilim = '0; wr = 1'b1; step(1); wr = 1'b0;

        // R8: warning edge
        temp = 8'd169; step(1);
        chk("R8 below warning", 32'(twarn), 32'h0);
        temp = 8'd170; step(1);
        chk("R8 at warning", 32'(twarn), 32'h1);

        // R7: thermal hysteresis
        temp = 8'd199; step(1);
        chk("R7 below shutdown", 32'(force_off), 32'h0);
        temp = 8'd200; step(1);
        chk("R7 at shutdown", 32'(force_off), 32'h1F);
        temp = 8'd185; step(1);
        chk("R7 hysteresis holds", 32'(force_off), 32'h1F);
        temp = 8'd184; step(1);
        chk("R7 released", 32'(force_off), 32'h0);
        temp = 8'd0; step(1);

        // Mixed random phase, checked against the model each cycle
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < NUM_OUT; i++) ilim[i] = (($urandom % 16) != 0);
            wr = (($urandom % 48) == 0);
            if (($urandom % 40) == 0) ovv = ~ovv;
            if (($urandom % 2) == 0) temp = temp + 8'(($urandom % 9));
            else                     temp = temp - 8'(($urandom % 9));
            step(1);
        end
        step(2);
        summary();
    end

endmodule